// File: doc/BRIEF.md
# Quasi-Bidirectional Port Bank with Change Interrupt

This block models a bank of general-purpose pins that has no direction register. Each bit has an output latch. A latch bit of 0 enables a strong low driver on its pin. A latch bit of 1 leaves the pin to a weak pull-up, so the pin reads high unless an external device pulls it low. A bit therefore works as an input whenever its latch holds 1. Each pin is modelled as a wired-AND of its latch bit and an active-high external pull-low request.

A write strobe loads the whole latch from the write data. A read strobe captures the sampled pin levels into an input snapshot register, and the read data port presents that register. The snapshot holds the actual pin levels, not the latch contents.

A change detector compares the sampled pins with the snapshot. A mismatch must last for a programmable number of consecutive clocks before the interrupt goes active. This acts as a low-pass filter. The interrupt is an enable for an open-drain low driver. A read strobe clears it, and a later change sets it again.

Top module: `qbp_port_bank`

## Requirements
- R1: After reset, every latch bit is 1, `pin_drive_low` is all 0, `rd_data` is all 1, `int_drive_low` is 0, and with no external pull-low every `pin_level` bit is 1.
- R2: A `wr_stb` in cycle t loads `wr_data` into the latch at that edge. From cycle t+1, each bit written 0 has `pin_drive_low`=1 and `pin_level`=0. The latch keeps its value until the next `wr_stb`.
- R3: A bit whose latch holds 1 is an input: its `pin_level` is 0 while `ext_pull_low` for that bit is 1, and 1 otherwise.
- R4: A `rd_stb` at an edge loads `rd_data` with the sampled pin levels at that edge, including bits whose latch is 1 but are pulled low externally. `rd_data` then holds its value until the next `rd_stb`.
- R5: With `FILT_CYCLES`=N, `int_drive_low` becomes 1 after the sampled pins have differed from `rd_data` at N consecutive clock edges with no `rd_stb`. It stays 1 while that condition holds.
- R6: A mismatch that lasts fewer than N consecutive edges never sets `int_drive_low`, and restarts the count when it ends.
- R7: A `rd_stb` clears `int_drive_low` at that same edge. It stays 0 while the pins match the new snapshot, and a later pin change sets it again after N edges.
- R8: Writing 1 to a bit that held 0 returns the pin to the pulled-up input state. This sets the interrupt only if the resulting level differs from the snapshot bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_stb | input | 1 | Load the output latch from `wr_data` |
| wr_data | input | WIDTH | New latch value |
| rd_stb | input | 1 | Capture the sampled pins into the snapshot |
| rd_data | output | WIDTH | Input snapshot (last read pin levels) |
| ext_pull_low | input | WIDTH | External device pulls the pin low (1 = pull) |
| pin_level | output | WIDTH | Resolved pin level |
| pin_drive_low | output | WIDTH | Enable of the strong low driver per pin |
| int_drive_low | output | 1 | Enable of the open-drain interrupt driver |

## Verification
The assertions assume that `ext_pull_low`, `wr_stb`, `wr_data` and `rd_stb` are synchronous to `clk` and stable around each rising edge. With the default of zero synchronizer stages, the sampled pins equal the resolved pins. The bench changes every input on the falling edge and samples outputs on the falling edge as well. It places each pin change a known number of edges before a read, so the filter count can be predicted.

// File: rtl/qbp_pkg.sv
package qbp_pkg;
   // Width of a counter that must hold values 0..n (never less than one bit).
   function automatic int unsigned cnt_width(input int unsigned n);
      int unsigned w;
      w = $clog2(n + 1);
      return (w < 1) ? 1 : w;
   endfunction
endpackage

// File: rtl/qbp_out_latch.sv
module qbp_out_latch #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_stb,
   input  logic [WIDTH-1:0] wr_data,
   output logic [WIDTH-1:0] latch_q
);
   if (WIDTH < 1) begin : g_bad_width
      $error("qbp_out_latch: WIDTH must be at least 1");
   end

   // Power-on value: every bit released to the pull-up.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      latch_q <= '1;
      else if (wr_stb) latch_q <= wr_data;
   end

   // R2: a strobe loads the data
   a_r2_write_load: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |=> (latch_q == $past(wr_data)));
   // R2: the latch holds without a strobe
   a_r2_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_stb |=> $stable(latch_q));
endmodule

// File: rtl/qbp_pin_net.sv
module qbp_pin_net #(
   parameter int unsigned WIDTH       = 8,
   parameter int unsigned SYNC_STAGES = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] latch_q,
   input  logic [WIDTH-1:0] ext_pull_low,
   output logic [WIDTH-1:0] pin_level,
   output logic [WIDTH-1:0] pin_sampled,
   output logic [WIDTH-1:0] drive_low
);
   if (SYNC_STAGES > 4) begin : g_bad_sync
      $error("qbp_pin_net: SYNC_STAGES above 4 is not supported");
   end

   // Per-bit wired-AND: a strong low from the latch or a low from outside wins.
   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      assign drive_low[i] = ~latch_q[i];
      assign pin_level[i] = latch_q[i] & ~ext_pull_low[i];
   end

   if (SYNC_STAGES == 0) begin : g_direct
      assign pin_sampled = pin_level;
   end else begin : g_sync
      logic [WIDTH-1:0] stage_q [SYNC_STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int s = 0; s < SYNC_STAGES; s++) stage_q[s] <= '1;
         end else begin
            stage_q[0] <= pin_level;
            for (int s = 1; s < SYNC_STAGES; s++) stage_q[s] <= stage_q[s-1];
         end
      end
      assign pin_sampled = stage_q[SYNC_STAGES-1];
   end

   // R2: a driven-low pin never reads high
   a_r2_driven_pin_low: assert property (@(posedge clk) disable iff (!rst_n)
      ((drive_low & pin_level) == '0));
   // R3: a high pin always has its low driver released
   a_r3_high_means_input: assert property (@(posedge clk) disable iff (!rst_n)
      ((pin_level & ~latch_q) == '0));
endmodule

// File: rtl/qbp_in_snapshot.sv
module qbp_in_snapshot #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd_stb,
   input  logic [WIDTH-1:0] pin_sampled,
   output logic [WIDTH-1:0] snap_q,
   output logic             mismatch
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      snap_q <= '1;
      else if (rd_stb) snap_q <= pin_sampled;
   end

   assign mismatch = |(snap_q ^ pin_sampled);

   // R4: a read captures the sampled pins
   a_r4_snap_capture: assert property (@(posedge clk) disable iff (!rst_n)
      rd_stb |=> (snap_q == $past(pin_sampled)));
   // R4: the snapshot holds between reads
   a_r4_snap_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_stb |=> $stable(snap_q));
endmodule

// File: rtl/qbp_change_filter.sv
module qbp_change_filter
   import qbp_pkg::*;
#(
   parameter int unsigned FILT_CYCLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rd_stb,
   input  logic mismatch,
   output logic irq
);
   localparam int unsigned CW = cnt_width(FILT_CYCLES);
   localparam logic [CW-1:0] LAST = CW'(FILT_CYCLES - 1);

   if (FILT_CYCLES < 1) begin : g_bad_filt
      $error("qbp_change_filter: FILT_CYCLES must be at least 1");
   end

   logic [CW-1:0] run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= '0;
         irq   <= 1'b0;
      end else if (rd_stb || !mismatch) begin
         run_q <= '0;
         irq   <= 1'b0;
      end else if (run_q == LAST) begin
         irq   <= 1'b1;
      end else begin
         run_q <= run_q + 1'b1;
      end
   end

   // R7: a read clears the interrupt
   a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      rd_stb |=> !irq);
   // R6: no interrupt follows a matching edge
   a_r6_match_clears: assert property (@(posedge clk) disable iff (!rst_n)
      !mismatch |=> !irq);
   // R5: the interrupt only rises after a full run
   a_r5_rise_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> ($past(run_q) == LAST));
   // R5: a set interrupt holds while the mismatch persists
   a_r5_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && mismatch && !rd_stb) |=> irq);
endmodule

// File: rtl/qbp_port_bank.sv
module qbp_port_bank #(
   parameter int unsigned WIDTH       = 8,
   parameter int unsigned FILT_CYCLES = 4,
   parameter int unsigned SYNC_STAGES = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_stb,
   input  logic [WIDTH-1:0] wr_data,
   input  logic             rd_stb,
   output logic [WIDTH-1:0] rd_data,
   input  logic [WIDTH-1:0] ext_pull_low,
   output logic [WIDTH-1:0] pin_level,
   output logic [WIDTH-1:0] pin_drive_low,
   output logic             int_drive_low
);
   logic [WIDTH-1:0] latch_q;
   logic [WIDTH-1:0] pin_sampled;
   logic             mismatch;

   qbp_out_latch #(.WIDTH(WIDTH)) u_latch (
      .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_data(wr_data),
      .latch_q(latch_q));

   qbp_pin_net #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)) u_pins (
      .clk(clk), .rst_n(rst_n), .latch_q(latch_q), .ext_pull_low(ext_pull_low),
      .pin_level(pin_level), .pin_sampled(pin_sampled), .drive_low(pin_drive_low));

   qbp_in_snapshot #(.WIDTH(WIDTH)) u_snap (
      .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .pin_sampled(pin_sampled),
      .snap_q(rd_data), .mismatch(mismatch));

   qbp_change_filter #(.FILT_CYCLES(FILT_CYCLES)) u_filt (
      .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .mismatch(mismatch),
      .irq(int_drive_low));

   // R1: reset releases every low driver and the interrupt
   a_r1_reset_state: assert property (@(posedge clk)
      $rose(rst_n) |-> (pin_drive_low == '0 && !int_drive_low));
endmodule

// File: tb/qbp_port_bank_tb.sv
module qbp_port_bank_tb;
   localparam int W = 8;
   localparam int N = 4;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         wr_stb = 1'b0;
   logic [W-1:0] wr_data = '0;
   logic         rd_stb = 1'b0;
   logic [W-1:0] rd_data;
   logic [W-1:0] ext_pull_low = '0;
   logic [W-1:0] pin_level;
   logic [W-1:0] pin_drive_low;
   logic         int_drive_low;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;

   qbp_port_bank #(.WIDTH(W), .FILT_CYCLES(N)) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_data(wr_data),
      .rd_stb(rd_stb), .rd_data(rd_data), .ext_pull_low(ext_pull_low),
      .pin_level(pin_level), .pin_drive_low(pin_drive_low),
      .int_drive_low(int_drive_low));

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s got=%h exp=%h", tag, got, exp);
      end
   endtask

   // Advance n rising edges; return on the following falling edge.
   task automatic step(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic do_write(input logic [W-1:0] d);
      wr_stb = 1'b1; wr_data = d;
      step(1);
      wr_stb = 1'b0;
   endtask

   task automatic do_read();
      rd_stb = 1'b1;
      step(1);
      rd_stb = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 pin_drive_low", 32'(pin_drive_low), 32'h00);
      chk("R1 rd_data", 32'(rd_data), 32'hFF);
      chk("R1 pin_level", 32'(pin_level), 32'hFF);
      chk("R1 int_drive_low", 32'(int_drive_low), 32'h0);
   endtask

   task automatic t_write_drive();
      do_write(8'hA5);
      chk("R2 drive_low after write", 32'(pin_drive_low), 32'h5A);
      chk("R2 pin_level after write", 32'(pin_level), 32'hA5);
      step(3);
      chk("R2 latch held", 32'(pin_level), 32'hA5);
      do_write(8'hFF);
      do_read();
   endtask

   task automatic t_input_pull();
      ext_pull_low = 8'h81;
      #1;
      chk("R3 external pull", 32'(pin_level), 32'h7E);
      chk("R3 no strong drive", 32'(pin_drive_low), 32'h00);
      do_read();
      chk("R4 read returns pins", 32'(rd_data), 32'h7E);
      ext_pull_low = 8'h00;
      do_write(8'h0F);
      do_read();
      chk("R4 read is pins not latch", 32'(rd_data), 32'h0F);
      ext_pull_low = 8'h03;
      step(2);
      chk("R4 snapshot held", 32'(rd_data), 32'h0F);
      do_read();
      chk("R4 mixed in/out read", 32'(rd_data), 32'h0C);
      ext_pull_low = 8'h00;
      do_write(8'hFF);
      do_read();
   endtask

   task automatic t_filter();
      ext_pull_low = 8'h10;
      step(N - 1);
      chk("R5 not yet after N-1", 32'(int_drive_low), 32'h0);
      step(1);
      chk("R5 set after N", 32'(int_drive_low), 32'h1);
      step(3);
      chk("R5 holds", 32'(int_drive_low), 32'h1);
      do_read();
      chk("R7 read clears", 32'(int_drive_low), 32'h0);
      step(N + 2);
      chk("R7 stays clear on match", 32'(int_drive_low), 32'h0);
      ext_pull_low = 8'h00;
      step(N);
      chk("R7 re-arms on change", 32'(int_drive_low), 32'h1);
      do_read();
   endtask

   task automatic t_glitch();
      ext_pull_low = 8'h04;
      step(N - 1);
      ext_pull_low = 8'h00;
      step(1);
      chk("R6 short mismatch ignored", 32'(int_drive_low), 32'h0);
      ext_pull_low = 8'h04;
      step(N - 1);
      chk("R6 count restarted", 32'(int_drive_low), 32'h0);
      ext_pull_low = 8'h00;
      step(2);
      chk("R6 still clear", 32'(int_drive_low), 32'h0);
   endtask

   task automatic t_writeback();
      do_write(8'hFE);
      do_write(8'hFF);
      chk("R8 pin back high", 32'(pin_level), 32'hFF);
      step(N + 1);
      chk("R8 brief low no irq", 32'(int_drive_low), 32'h0);
      ext_pull_low = 8'h01;
      do_write(8'hFE);
      do_read();
      chk("R8 snapshot low", 32'(rd_data), 32'hFE);
      do_write(8'hFF);
      chk("R8 input low by outside", 32'(pin_level), 32'hFE);
      step(N + 1);
      chk("R8 same level no irq", 32'(int_drive_low), 32'h0);
      ext_pull_low = 8'h00;
      step(N);
      chk("R8 differs sets irq", 32'(int_drive_low), 32'h1);
      do_read();
      chk("R8 read clears", 32'(int_drive_low), 32'h0);
   endtask

   initial begin
      step(2);
      rst_n = 1'b1;
      step(1);
      t_reset();
      t_write_drive();
      t_input_pull();
      t_filter();
      t_glitch();
      t_writeback();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule